// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block is the bit-clock engine of an I2C master. It drives the SCL line and marks out bit phases in cycles of the source clock, using three programmable counts. A low-period count and a high-period count set the SCL duty cycle on their own. A start-hold count sets how long SCL stays high after SDA has dropped for a START. A byte engine sits above the timer. It asks for one bus condition at a time (start, data bit, stop or nothing), and it moves SDA on the strobes it gets back. The timer never drives SDA itself.

Each of the two 32-bit periods is split over two 32-bit divider words as 16-bit halves. A sampled copy of the SCL wire lets a target stretch the high phases. The controller is a state machine with nine states:

- `ST_IDLE`: bus released.
- `ST_HOLD`: start hold.
- `ST_BIT_LO`, `ST_BIT_HI`: data bit.
- `ST_PARK`: SCL held low while waiting for a request.
- `ST_RS_LO`, `ST_RS_HI`: repeated-start set-up.
- `ST_STOP_LO`, `ST_STOP_HI`: stop.

The transitions are:

- IDLE→HOLD when a start is requested.
- HOLD or BIT_HI→(BIT_LO | RS_LO | STOP_LO | PARK) when the phase ends. This dispatch picks the next state from the request.
- PARK→the same dispatch targets.
- BIT_LO→BIT_HI.
- RS_LO→RS_HI→HOLD.
- STOP_LO→STOP_HI→IDLE.
- Any state→IDLE when disabled.

Top module: `i2c_scl_timer`

## Requirements
- R1: The high count is {div_b[31:16], div_a[31:16]} and the low count is {div_b[15:0], div_a[15:0]}. Both are in source-clock cycles.
- R2: Every low phase lasts max(low,1) cycles. Every data high phase lasts max(high,1) cycles while the SCL line is not held low by a target.
- R3: A start request (bus_req code 1) in idle is accepted at once. SCL then stays high with start_mark set for max(hold,1) cycles and then falls.
- R4: sda_chg pulses once per low phase (data, repeated start, stop), at cycle floor(L/2) of that phase. sda_smp pulses once per data high phase, in the advancing cycle where the count reaches floor(H/2).
- R5: While scl_out is high but scl_in is low, a high-phase count does not advance. Each stretch cycle lengthens the phase by one cycle and delays sda_smp by one cycle. The start hold is not stretched.
- R6: A stop request (code 3) gives a low phase of L cycles, then a high phase of H cycles with stop_mark set. The block then goes idle with scl_out high and stop_mark low.
- R7: A start request (code 1) while the bus is owned gives a low phase of L cycles and a stretchable high of H cycles, then a start hold as in R3.
- R8: Requests are taken only in idle (start only), at the end of a start hold, at the end of a data high phase, or while parked. req_taken pulses in the taking cycle. A data request is code 2. An idle request (code 0) at a taking point parks SCL low, with no strobes, until another request arrives.
- R9: In idle, data and stop requests are ignored: scl_out stays high and req_taken stays low.
- R10: During reset, and one cycle after enable goes low, scl_out is high, both markers are low and the phase counter is cleared. A later start therefore gets the full hold length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces idle |
| div_a | input | DIV_W | Lower halves: high count bits 31:16, low count bits 15:0 |
| div_b | input | DIV_W | Upper halves: high count bits 31:16, low count bits 15:0 |
| hold_len | input | HOLD_W | Start-hold length in cycles |
| bus_req | input | 2 | Requested condition: 0 idle, 1 start, 2 data, 3 stop |
| scl_in | input | 1 | Sampled SCL wire level |
| req_taken | output | 1 | Pulse: the present request was accepted |
| scl_out | output | 1 | 1 releases SCL, 0 pulls it low |
| sda_chg | output | 1 | Strobe to change SDA (mid-low) |
| sda_smp | output | 1 | Strobe to sample SDA (mid-high) |
| start_mark | output | 1 | Start hold in progress (SDA must be low) |
| stop_mark | output | 1 | Stop condition in progress |

## Verification
scl_out and the two markers come from the state register, so they change one cycle after the edge that decides a transition. sda_chg, sda_smp and req_taken are decoded from the present state and count, so they are valid within the cycle they refer to. The bench changes bus_req only in the cycle after a req_taken. It samples every output at mid-cycle and measures each SCL run by counting those samples. It compares each run's length, strobe offset and marker count with values worked out from the programmed counts and the stretch it applies.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_START = 2'd1,
        REQ_DATA  = 2'd2,
        REQ_STOP  = 2'd3
    } bus_req_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HOLD,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_PARK,
        ST_RS_LO,
        ST_RS_HI,
        ST_STOP_LO,
        ST_STOP_HI
    } scl_state_e;

    typedef enum logic [1:0] {
        LEN_NONE,
        LEN_LOW,
        LEN_HIGH,
        LEN_HOLD
    } len_sel_e;

endpackage

// File: rtl/i2c_scl_div_unpack.sv
module i2c_scl_div_unpack #(
    parameter int DIV_W = 32
) (
    input  logic [DIV_W-1:0] word_a,
    input  logic [DIV_W-1:0] word_b,
    output logic [DIV_W-1:0] high_len,
    output logic [DIV_W-1:0] low_len
);
    localparam int HALF = DIV_W / 2;

    // Upper halves of both words carry the high period, lower halves the low period.
    assign high_len = {word_b[DIV_W-1:HALF], word_a[DIV_W-1:HALF]};
    assign low_len  = {word_b[HALF-1:0],     word_a[HALF-1:0]};

endmodule

// File: rtl/i2c_scl_phase_cnt.sv
module i2c_scl_phase_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] len,
    output logic             at_mid,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    // A zero length behaves as a one-cycle phase.
    assign last_idx = (len == '0) ? '0 : (len - 1'b1);
    assign at_last  = (cnt_q == last_idx);
    assign at_mid   = (cnt_q == (len >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv && !at_last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: a stalled count (stretch) keeps its value
    a_r5_count_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_scl_fsm.sv
module i2c_scl_fsm
    import i2c_scl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic [1:0] bus_req,
    input  logic     scl_in,
    input  logic     at_mid,
    input  logic     at_last,
    output len_sel_e len_sel,
    output logic     cnt_clr,
    output logic     cnt_adv,
    output logic     req_taken,
    output logic     scl_out,
    output logic     sda_chg,
    output logic     sda_smp,
    output logic     start_mark,
    output logic     stop_mark
);
    scl_state_e state_q;
    scl_state_e state_d;
    bus_req_e   req;
    logic       is_high_ph;
    logic       is_low_ph;
    logic       phase_end;
    logic       take;

    assign req        = bus_req_e'(bus_req);
    assign is_high_ph = (state_q == ST_BIT_HI) || (state_q == ST_RS_HI) || (state_q == ST_STOP_HI);
    assign is_low_ph  = (state_q == ST_BIT_LO) || (state_q == ST_RS_LO) || (state_q == ST_STOP_LO);

    // High phases advance only while the wire is really high.
    assign cnt_adv   = is_low_ph || (state_q == ST_HOLD) || (is_high_ph && scl_in);
    assign phase_end = cnt_adv && at_last;
    assign cnt_clr   = !enable || phase_end || (state_q == ST_IDLE) || (state_q == ST_PARK);
    assign req_taken = take && enable;

    function automatic scl_state_e dispatch(input bus_req_e r);
        scl_state_e nxt;
        unique case (r)
            REQ_START: nxt = ST_RS_LO;
            REQ_DATA:  nxt = ST_BIT_LO;
            REQ_STOP:  nxt = ST_STOP_LO;
            default:   nxt = ST_PARK;
        endcase
        return nxt;
    endfunction

    // Next-state logic
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req == REQ_START) begin
                    state_d = ST_HOLD;
                    take    = 1'b1;
                end
            end
            ST_HOLD, ST_BIT_HI: begin
                if (phase_end) begin
                    state_d = dispatch(req);
                    take    = (req != REQ_IDLE);
                end
            end
            ST_PARK: begin
                state_d = dispatch(req);
                take    = (req != REQ_IDLE);
            end
            ST_BIT_LO:  if (phase_end) state_d = ST_BIT_HI;
            ST_RS_LO:   if (phase_end) state_d = ST_RS_HI;
            ST_RS_HI:   if (phase_end) state_d = ST_HOLD;
            ST_STOP_LO: if (phase_end) state_d = ST_STOP_HI;
            ST_STOP_HI: if (phase_end) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (!enable) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        scl_out    = 1'b1;
        sda_chg    = 1'b0;
        sda_smp    = 1'b0;
        start_mark = 1'b0;
        stop_mark  = 1'b0;
        len_sel    = LEN_NONE;
        unique case (state_q)
            ST_IDLE: begin
                scl_out = 1'b1;
            end
            ST_HOLD: begin
                start_mark = 1'b1;
                len_sel    = LEN_HOLD;
            end
            ST_BIT_LO: begin
                scl_out = 1'b0;
                sda_chg = at_mid;
                len_sel = LEN_LOW;
            end
            ST_BIT_HI: begin
                sda_smp = at_mid && scl_in;
                len_sel = LEN_HIGH;
            end
            ST_PARK: begin
                scl_out = 1'b0;
            end
            ST_RS_LO: begin
                scl_out = 1'b0;
                sda_chg = at_mid;
                len_sel = LEN_LOW;
            end
            ST_RS_HI: begin
                len_sel = LEN_HIGH;
            end
            ST_STOP_LO: begin
                scl_out   = 1'b0;
                sda_chg   = at_mid;
                stop_mark = 1'b1;
                len_sel   = LEN_LOW;
            end
            ST_STOP_HI: begin
                stop_mark = 1'b1;
                len_sel   = LEN_HIGH;
            end
            default: begin
                scl_out = 1'b1;
            end
        endcase
    end

    // R10: one cycle after enable drops the bus is released
    a_r10_disable_release : assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !start_mark && !stop_mark));

    // R3: a start hold is only ever entered with SCL already high
    a_r3_start_from_high : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_mark) |-> $past(scl_out));

    // R6: the stop condition ends with SCL released
    a_r6_stop_release : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_mark) |-> scl_out);

    // R5: SDA is never sampled while the wire is held low
    a_r5_smp_line_high : assert property (@(posedge clk) disable iff (!rst_n)
        sda_smp |-> scl_in);

    // R8: requests are accepted only at phase boundaries, in idle or parked
    a_r8_take_boundary : assert property (@(posedge clk) disable iff (!rst_n)
        req_taken |-> ((state_q == ST_IDLE) || (state_q == ST_PARK) || phase_end));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_pkg::*;
#(
    parameter int DIV_W  = 32,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_a,
    input  logic [DIV_W-1:0]  div_b,
    input  logic [HOLD_W-1:0] hold_len,
    input  logic [1:0]        bus_req,
    input  logic              scl_in,
    output logic              req_taken,
    output logic              scl_out,
    output logic              sda_chg,
    output logic              sda_smp,
    output logic              start_mark,
    output logic              stop_mark
);
    localparam int CNT_W = (DIV_W > HOLD_W) ? DIV_W : HOLD_W;

    logic [DIV_W-1:0] high_len;
    logic [DIV_W-1:0] low_len;
    logic [CNT_W-1:0] ph_len;
    len_sel_e         len_sel;
    logic             cnt_clr;
    logic             cnt_adv;
    logic             at_mid;
    logic             at_last;

    i2c_scl_div_unpack #(.DIV_W(DIV_W)) u_unpack (
        .word_a   (div_a),
        .word_b   (div_b),
        .high_len (high_len),
        .low_len  (low_len)
    );

    always_comb begin
        unique case (len_sel)
            LEN_LOW:  ph_len = CNT_W'(low_len);
            LEN_HIGH: ph_len = CNT_W'(high_len);
            LEN_HOLD: ph_len = CNT_W'(hold_len);
            default:  ph_len = '0;
        endcase
    end

    i2c_scl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .adv     (cnt_adv),
        .len     (ph_len),
        .at_mid  (at_mid),
        .at_last (at_last)
    );

    i2c_scl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .bus_req    (bus_req),
        .scl_in     (scl_in),
        .at_mid     (at_mid),
        .at_last    (at_last),
        .len_sel    (len_sel),
        .cnt_clr    (cnt_clr),
        .cnt_adv    (cnt_adv),
        .req_taken  (req_taken),
        .scl_out    (scl_out),
        .sda_chg    (sda_chg),
        .sda_smp    (sda_smp),
        .start_mark (start_mark),
        .stop_mark  (stop_mark)
    );

endmodule

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] div_a = '0;
    logic [31:0] div_b = '0;
    logic [15:0] hold_len = '0;
    logic [1:0]  bus_req = 2'd0;
    logic        scl_in = 1'b1;
    logic        req_taken, scl_out, sda_chg, sda_smp, start_mark, stop_mark;

    always #2.5 clk = ~clk;

    i2c_scl_timer u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_a(div_a), .div_b(div_b),
        .hold_len(hold_len), .bus_req(bus_req), .scl_in(scl_in),
        .req_taken(req_taken), .scl_out(scl_out), .sda_chg(sda_chg),
        .sda_smp(sda_smp), .start_mark(start_mark), .stop_mark(stop_mark)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit timed_out = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stimulus table: logical low/high counts, hold, stretch cycles, data bits, restart
    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [15:0] hold;
        logic [7:0]  str;
        logic [7:0]  nb;
        logic        rs;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'd6, 32'd4, 16'd3, 8'd0, 8'd2, 1'b0},
        '{32'd7, 32'd5, 16'd2, 8'd0, 8'd1, 1'b0},
        '{32'd1, 32'd1, 16'd1, 8'd0, 8'd2, 1'b0},
        '{32'd0, 32'd0, 16'd0, 8'd0, 8'd1, 1'b0},
        '{32'd8, 32'd6, 16'd4, 8'd3, 8'd2, 1'b0},
        '{32'd5, 32'd4, 16'd2, 8'd1, 8'd1, 1'b1}
    };

    int    e_len [32];
    int    e_pos [32];
    int    e_sm  [32];
    string e_tag [32];
    int    ne;

    task automatic push_exp(input int len, input int pos, input int sm, input string tag);
        e_len[ne] = len; e_pos[ne] = pos; e_sm[ne] = sm; e_tag[ne] = tag;
        ne++;
    endtask

    task automatic measure_run(input logic lvl, output int n);
        n = 0;
        while (scl_out == lvl && n < 70000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int L, H, Hd, s, n, idx, cyc, st_left, nr, k;
        int scr [16];
        logic r_lvl [32];
        int r_len [32], r_pos [32], r_sm [32];
        bit pend, rec, seen_stop, newrun;
        L  = (v.lo == 0) ? 1 : int'(v.lo);
        H  = (v.hi == 0) ? 1 : int'(v.hi);
        Hd = (v.hold == 0) ? 1 : int'(v.hold);
        s  = int'(v.str);
        // script of requests: 1 start, 2 data, 3 stop
        n = 0;
        scr[n++] = 1;
        for (int b = 0; b < int'(v.nb); b++) scr[n++] = 2;
        if (v.rs) begin
            scr[n++] = 1;
            for (int b = 0; b < int'(v.nb); b++) scr[n++] = 2;
        end
        scr[n++] = 3;
        // expected SCL runs from the requirements
        ne = 0;
        push_exp(Hd, -1, Hd, "R3");
        for (int b = 0; b < int'(v.nb); b++) begin
            push_exp(L, L / 2, 0, "R2");
            push_exp(H + s, s + H / 2, 0, (s > 0) ? "R5" : "R2");
        end
        if (v.rs) begin
            push_exp(L, L / 2, 0, "R7");
            push_exp(H + s + Hd, -1, Hd, "R7");
            for (int b = 0; b < int'(v.nb); b++) begin
                push_exp(L, L / 2, 0, "R2");
                push_exp(H + s, s + H / 2, 0, (s > 0) ? "R5" : "R2");
            end
        end
        push_exp(L, L / 2, 0, "R6");
        push_exp(H, -1, 0, "R6");

        @(negedge clk);
        div_a = {v.hi[15:0], v.lo[15:0]};
        div_b = {v.hi[31:16], v.lo[31:16]};
        hold_len = v.hold;
        bus_req = 2'(scr[0]);
        idx = 0; st_left = 0; nr = 0;
        rec = 0; seen_stop = 0;
        #2;
        check("R3 start taken in idle", int'(req_taken), 1);
        pend = req_taken;
        cyc = 0;
        while (cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (pend) begin
                idx++;
                bus_req = (idx < n) ? 2'(scr[idx]) : 2'd0;
                pend = 0;
                rec = 1;
            end
            #1;
            if (rec && seen_stop && !stop_mark) break;
            if (stop_mark) seen_stop = 1;
            newrun = rec && (nr == 0 || scl_out != r_lvl[nr-1]);
            if (newrun && scl_out && !start_mark && !stop_mark) st_left = s;
            scl_in = (st_left == 0);
            if (st_left > 0) st_left--;
            #1;
            if (req_taken) pend = 1;
            if (rec) begin
                if (newrun) begin
                    if (nr < 32) begin
                        r_lvl[nr] = scl_out; r_len[nr] = 0; r_pos[nr] = -1; r_sm[nr] = 0;
                        nr++;
                    end
                end
                k = nr - 1;
                if ((scl_out ? sda_smp : sda_chg) && r_pos[k] < 0) r_pos[k] = r_len[k];
                if (start_mark) r_sm[k]++;
                r_len[k]++;
            end
        end
        scl_in = 1'b1;
        bus_req = 2'd0;
        check("R6 idle after stop", int'(scl_out), 1);
        check("R2 run count", nr, ne);
        for (int i = 0; i < ne && i < nr; i++) begin
            check({e_tag[i], " run length"}, r_len[i], e_len[i]);
            check("R4 strobe offset", r_pos[i], e_pos[i]);
            check({e_tag[i], " start marker cycles"}, r_sm[i], e_sm[i]);
        end
    endtask

    task automatic run_all();
        int m;
        // reset state (R10)
        repeat (3) @(negedge clk);
        #1;
        check("R10 reset scl", int'(scl_out), 1);
        check("R10 reset markers", int'(start_mark | stop_mark), 0);
        check("R10 reset strobes", int'(sda_chg | sda_smp | req_taken), 0);
        @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;
        div_a = {16'd4, 16'd4};
        div_b = '0;
        hold_len = 16'd2;

        // R9: data and stop ignored in idle
        for (int c = 2; c <= 3; c++) begin
            @(negedge clk);
            bus_req = 2'(c);
            for (int i = 0; i < 5; i++) begin
                #1;
                check("R9 scl stays high", int'(scl_out), 1);
                check("R9 not taken", int'(req_taken), 0);
                @(negedge clk);
            end
            bus_req = 2'd0;
        end

        // table walk
        for (int v = 0; v < NV; v++) run_vec(VECS[v]);

        // R8: park with idle request, then stop
        @(negedge clk);
        div_a = {16'd4, 16'd4}; div_b = '0; hold_len = 16'd2;
        bus_req = 2'd1;
        @(negedge clk);
        bus_req = 2'd2;
        #1;
        measure_run(1'b1, m);
        check("R3 hold before park", m, 2);
        bus_req = 2'd0;
        measure_run(1'b0, m);
        check("R2 low before park", m, 4);
        measure_run(1'b1, m);
        check("R2 high before park", m, 4);
        for (int i = 0; i < 10; i++) begin
            check("R8 parked scl low", int'(scl_out), 0);
            check("R8 parked no strobe", int'(sda_chg | sda_smp | req_taken), 0);
            @(negedge clk); #1;
        end
        bus_req = 2'd3;
        #1;
        check("R8 stop taken from park", int'(req_taken), 1);
        @(negedge clk);
        bus_req = 2'd0;
        #1;
        check("R6 stop marker", int'(stop_mark), 1);
        measure_run(1'b0, m);
        check("R6 stop low", m, 4);
        m = 0;
        while (stop_mark && m < 100) begin
            m++;
            @(negedge clk); #1;
        end
        check("R6 stop high", m, 4);
        check("R6 released", int'(scl_out), 1);

        // R1: upper halves of both words, then R10 disable mid-bit
        @(negedge clk);
        div_a = 32'h0001_0002;
        div_b = 32'h0001_0001;
        hold_len = 16'd2;
        bus_req = 2'd1;
        @(negedge clk);
        bus_req = 2'd2;
        #1;
        measure_run(1'b1, m);
        check("R3 hold", m, 2);
        measure_run(1'b0, m);
        check("R1 low count 65538", m, 65538);
        measure_run(1'b1, m);
        check("R1 high count 65537", m, 65537);
        @(negedge clk);
        enable = 1'b0;
        bus_req = 2'd0;
        #1;
        check("R10 still low before disable edge", int'(scl_out), 0);
        @(negedge clk); #1;
        check("R10 disable releases scl", int'(scl_out), 1);
        check("R10 disable markers", int'(start_mark | stop_mark), 0);
        enable = 1'b1;
        div_a = {16'd4, 16'd4}; div_b = '0; hold_len = 16'd3;
        bus_req = 2'd1;
        @(negedge clk);
        bus_req = 2'd0;
        #1;
        measure_run(1'b1, m);
        check("R10 full hold after re-enable", m, 3);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk); #1;
        check("R10 released at end", int'(scl_out), 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (195000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=expired expected=finished");
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule